// File: doc/BRIEF.md
# Min-Plus Closure Array Stage

One processing stage of a linear array that computes shortest-path closure of an N×N matrix over the min-plus semiring. Each stage performs one relaxation step of the dynamic-programming closure, using node 0 as the intermediate node. The values are unsigned words, and the all-ones word stands for "no path" (infinity). The matrix enters as a row-major stream of elements under a valid/ready handshake and leaves on an identical stream. Stages can therefore be chained directly, or one stage can be fed its own result again.

The stage renumbers the nodes as the data passes through. Every index drops by one, modulo N, so the node used as the intermediate by the next step again sits at row 0 and column 0. The stage keeps the relaxed row 0 in a local row buffer and emits nothing while that row arrives. Each later row is relaxed column by column. The row's column-0 entry is held back and emitted after the row's other entries. The buffered row 0 goes out last. After N passes the matrix is the full closure in its original numbering, and further passes only rotate the indices.

Top module: `mpc_stage`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Product is a saturating add: the result is the all-ones word if either operand is all-ones or the true sum does not fit in W bits. Sum is unsigned minimum.
- R3: For input m, row 0 is relaxed as p(j) = min(m(0,j), m(0,0)+m(0,j)). Every other entry is relaxed as u(i,j) = min(m(i,j), m(i,0)+p(j)), using the product and sum of R2.
- R4: The output element at new position ((i-1) mod N, (j-1) mod N) equals the relaxed entry (i,j), and the output is row-major in the new positions. So rows 1..N-1 leave first, each as columns 1..N-1 followed by column 0, and the buffered row 0 leaves last in the same column order.
- R5: No element is emitted while row 0 of the first matrix arrives. With no stalls on either side, the first output element is presented N+2 clock cycles after the first input element is accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. Every accepted element yields exactly one output element: none is lost or duplicated.
- R7: The buffered row 0 is fully placed on the output before row 0 of the next matrix is accepted. Accepted-but-unemitted elements never exceed N+2. With `out_ready` held at 1, the first element of a following matrix is accepted N+2 cycles after the previous matrix's last element.
- R8: Feeding a matrix through the stage N times yields its min-plus closure in the original numbering. One more pass yields the same closure with every row and column index lowered by one modulo N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Stage accepts the input element this cycle |
| in_data | input | W | Input matrix element, row-major order |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Downstream accepts the output element |
| out_data | output | W | Output matrix element, row-major in the renumbered order |

## Verification
The bench feeds matrices with near-maximal weights. A sum that wraps instead of saturating would report a short path where none exists. It checks that column 0 of each row comes out after that row's other columns, and that the buffered row comes out after every other row. A stage that kept the original numbering would put every element in the wrong slot. It stalls the output at random and inserts input bubbles, which exposes dropped or repeated elements and a pivot row overwritten by the next matrix before it has drained. Chaining N+1 passes and comparing against an independently computed closure catches a pivot applied to the wrong row or column.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    // Phases of one matrix pass through the stage
    typedef enum logic [1:0] {
        PH_PIVOT = 2'd0,   // collecting and relaxing row 0 into the buffer
        PH_BODY  = 2'd1,   // relaxing rows 1..N-1 and streaming them out
        PH_DRAIN = 2'd2    // emitting deferred column 0 and the buffered row
    } mpc_phase_e;

endpackage

// File: rtl/mpc_mac.sv
// Min-plus multiply-accumulate: res = min(acc, a (+sat) b)
module mpc_mac #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mul_a_i,
    input  logic [W-1:0] mul_b_i,
    output logic [W-1:0] res_o
);
    localparam logic [W-1:0] INF = '1;

    logic [W:0]   sum;
    logic [W-1:0] prod;

    always_comb begin
        sum = {1'b0, mul_a_i} + {1'b0, mul_b_i};
        if (mul_a_i == INF || mul_b_i == INF || sum[W]) begin
            prod = INF;
        end else begin
            prod = sum[W-1:0];
        end
        res_o = (prod < acc_i) ? prod : acc_i;
    end

endmodule

// File: rtl/mpc_rowbuf.sv
// Single-row storage for the relaxed pivot row: one write port,
// one addressed read port and a fixed read of entry 0.
module mpc_rowbuf #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  head_data
);
    logic [W-1:0] ent_d [N];
    logic [W-1:0] ent_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && wr_addr == IW'(g)) begin
                ent_d[g] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        ent_q <= ent_d;
    end

    assign rd_data   = ent_q[rd_addr];
    assign head_data = ent_q[0];

endmodule

// File: rtl/mpc_stage.sv
module mpc_stage
    import mpc_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int            IW   = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    typedef struct packed {
        mpc_phase_e    ph;
        logic [IW-1:0] row;    // row index of the next input element
        logic [IW-1:0] col;    // column index of the next input element
        logic [IW-1:0] dcnt;   // drain position
        logic          pend;   // a deferred column-0 result is waiting
        logic [W-1:0]  hold;   // deferred column-0 result
        logic [W-1:0]  colv;   // raw column-0 value of the current row
        logic          ov;     // output register valid
        logic [W-1:0]  od;     // output register data
    } st_t;

    st_t s_d, s_q;

    logic          ready_c;
    logic          slot_free;
    logic          wr_en;
    logic [IW-1:0] rd_addr;
    logic [IW-1:0] dcol;
    logic [W-1:0]  buf_rd, buf_head;
    logic [W-1:0]  mac_a, mac_b, mac_r;

    mpc_rowbuf #(.N(N), .W(W), .IW(IW)) rowbuf_i (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (s_q.col),
        .wr_data   (mac_r),
        .rd_addr   (rd_addr),
        .rd_data   (buf_rd),
        .head_data (buf_head)
    );

    mpc_mac #(.W(W)) mac_i (
        .acc_i   (in_data),
        .mul_a_i (mac_a),
        .mul_b_i (mac_b),
        .res_o   (mac_r)
    );

    assign slot_free = !s_q.ov || out_ready;
    assign dcol      = (s_q.dcnt == LAST) ? '0 : s_q.dcnt + 1'b1;

    always_comb begin
        s_d     = s_q;
        ready_c = 1'b0;
        wr_en   = 1'b0;
        rd_addr = s_q.col;
        mac_a   = in_data;
        mac_b   = in_data;

        if (s_q.ov && out_ready) begin
            s_d.ov = 1'b0;
        end

        case (s_q.ph)
            PH_PIVOT: begin
                ready_c = 1'b1;
                mac_a   = (s_q.col == '0) ? in_data : buf_head;
                mac_b   = in_data;
                if (in_valid) begin
                    wr_en = 1'b1;
                    if (s_q.col == LAST) begin
                        s_d.ph  = PH_BODY;
                        s_d.col = '0;
                        s_d.row = IW'(1);
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                end
            end

            PH_BODY: begin
                if (s_q.col == '0) begin
                    ready_c = !s_q.pend || slot_free;
                    mac_a   = buf_head;
                    mac_b   = in_data;
                    if (in_valid && ready_c) begin
                        if (s_q.pend) begin
                            s_d.ov = 1'b1;
                            s_d.od = s_q.hold;
                        end
                        s_d.hold = mac_r;
                        s_d.colv = in_data;
                        s_d.pend = 1'b1;
                        s_d.col  = IW'(1);
                    end
                end else begin
                    ready_c = slot_free;
                    rd_addr = s_q.col;
                    mac_a   = s_q.colv;
                    mac_b   = buf_rd;
                    if (in_valid && ready_c) begin
                        s_d.ov = 1'b1;
                        s_d.od = mac_r;
                        if (s_q.col == LAST) begin
                            s_d.col = '0;
                            if (s_q.row == LAST) begin
                                s_d.ph   = PH_DRAIN;
                                s_d.dcnt = '0;
                            end else begin
                                s_d.row = s_q.row + 1'b1;
                            end
                        end else begin
                            s_d.col = s_q.col + 1'b1;
                        end
                    end
                end
            end

            PH_DRAIN: begin
                rd_addr = dcol;
                if (slot_free) begin
                    s_d.ov = 1'b1;
                    if (s_q.pend) begin
                        s_d.od   = s_q.hold;
                        s_d.pend = 1'b0;
                    end else begin
                        s_d.od = buf_rd;
                        if (s_q.dcnt == LAST) begin
                            s_d.ph   = PH_PIVOT;
                            s_d.dcnt = '0;
                            s_d.col  = '0;
                        end else begin
                            s_d.dcnt = s_q.dcnt + 1'b1;
                        end
                    end
                end
            end

            default: begin
                s_d.ph = PH_PIVOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = ready_c;
    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;

endmodule

// File: rtl/mpc_stage_chk.sv
module mpc_stage_chk #(
    parameter int N = 8,
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data
);
    logic [31:0] icnt_q, ocnt_q, fcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt_q <= '0;
            ocnt_q <= '0;
            fcnt_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                icnt_q <= icnt_q + 1;
                if (fcnt_q < 32'(N + 2)) fcnt_q <= fcnt_q + 1;
            end
            if (out_valid && out_ready) ocnt_q <= ocnt_q + 1;
        end
    end

    // R5
    first_out_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fcnt_q >= 32'(N + 2)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ocnt_q <= icnt_q);

    // R7
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (icnt_q - ocnt_q) <= 32'(N + 2));

endmodule

bind mpc_stage mpc_stage_chk #(.N(N), .W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/mpc_stage_tb_top.sv
module mpc_stage_tb_top;
    localparam int N   = 4;
    localparam int W   = 8;
    localparam int NN  = N * N;
    localparam int MEM = 1024;
    localparam logic [W-1:0] INF = '1;

    typedef logic [W-1:0] mat_t [NN];

    // stimulus table: three 4x4 matrices, row-major
    localparam logic [W-1:0] VEC [3*NN] = '{
        8'h00, 8'h03, 8'hFF, 8'h07,
        8'h08, 8'h00, 8'h02, 8'hFF,
        8'h05, 8'hFF, 8'h00, 8'h01,
        8'h02, 8'hFF, 8'hFF, 8'h00,
        8'hF0, 8'h20, 8'hFF, 8'h01,
        8'h10, 8'h00, 8'hFF, 8'h05,
        8'h80, 8'hE0, 8'h30, 8'hFF,
        8'h02, 8'hFF, 8'h40, 8'h00,
        8'h01, 8'h02, 8'h03, 8'h04,
        8'h05, 8'h06, 8'h07, 8'h08,
        8'h09, 8'h0A, 8'h0B, 8'h0C,
        8'h0D, 8'h0E, 8'h0F, 8'h10
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_data;
    logic         out_valid;
    logic         out_ready;
    logic [W-1:0] out_data;

    always #5 clk = ~clk;

    mpc_stage #(.N(N), .W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // shared memories: each written by one process only
    logic [W-1:0] in_mem  [MEM];
    logic [W-1:0] exp_mem [MEM];
    string        exp_tag [MEM];
    int           in_cyc  [MEM];
    int           out_cyc [MEM];
    int in_wr = 0, exp_wr = 0;
    int in_rd = 0;
    int nin = 0, nout = 0, cyc = 0;
    int mon_chk = 0, mon_err = 0, main_chk = 0, main_err = 0;
    bit bp_mode = 1'b0, gap_mode = 1'b0;
    bit hold_prev = 1'b0;
    logic [W-1:0] hold_val = '0;

    // ---------------- reference model ----------------
    function automatic logic [W-1:0] smul(logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (a == INF || b == INF || s[W]) return INF;
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] smin(logic [W-1:0] a, logic [W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic mat_t step_model(mat_t m);
        mat_t r;
        logic [W-1:0] p [N];
        for (int j = 0; j < N; j++) p[j] = smin(m[j], smul(m[0], m[j]));
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                logic [W-1:0] u;
                u = (i == 0) ? p[j] : smin(m[i*N+j], smul(m[i*N], p[j]));
                r[((i+N-1)%N)*N + (j+N-1)%N] = u;
            end
        end
        return r;
    endfunction

    function automatic mat_t fw_model(mat_t m);
        mat_t d = m;
        for (int k = 0; k < N; k++)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    d[i*N+j] = smin(d[i*N+j], smul(d[i*N+k], d[k*N+j]));
        return d;
    endfunction

    function automatic mat_t rot_model(mat_t m);
        mat_t r;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                r[((i+N-1)%N)*N + (j+N-1)%N] = m[i*N+j];
        return r;
    endfunction

    // ---------------- input driver ----------------
    initial begin
        in_valid = 1'b0;
        in_data  = '0;
        forever begin
            @(negedge clk);
            #1;
            if (in_rd < in_wr && !(gap_mode && ($urandom % 4 == 0))) begin
                in_valid = 1'b1;
                in_data  = in_mem[in_rd];
                #2;
                while (!in_ready) begin
                    @(negedge clk);
                    #3;
                end
                in_rd++;
            end else begin
                in_valid = 1'b0;
            end
        end
    end

    // ---------------- output backpressure ----------------
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            #1;
            out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    // ---------------- monitor (samples just before each rising edge) ----------------
    always @(negedge clk) begin
        #4;
        cyc++;
        if (hold_prev) begin
            mon_chk++;
            if (!(out_valid && out_data == hold_val)) begin
                mon_err++;
                $display("FAIL R6 stall hold: got valid=%0b data=%h expected valid=1 data=%h",
                         out_valid, out_data, hold_val);
            end
        end
        hold_prev = out_valid && !out_ready;
        hold_val  = out_data;
        if (in_valid && in_ready) begin
            if (nin < MEM) in_cyc[nin] = cyc;
            nin++;
        end
        if (out_valid && out_ready) begin
            if (nout < MEM) out_cyc[nout] = cyc;
            mon_chk++;
            if (nout >= exp_wr) begin
                mon_err++;
                $display("FAIL R6 extra output #%0d: got %h expected none", nout, out_data);
            end else if (out_data !== exp_mem[nout]) begin
                mon_err++;
                $display("FAIL %s output #%0d: got %h expected %h",
                         exp_tag[nout], nout, out_data, exp_mem[nout]);
            end
            nout++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(bit ok, string tag, int act, int expv);
        main_chk++;
        if (!ok) begin
            main_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push(mat_t m, mat_t e, string tag);
        for (int k = 0; k < NN; k++) begin
            in_mem[in_wr + k]   = m[k];
            exp_mem[exp_wr + k] = e[k];
            exp_tag[exp_wr + k] = tag;
        end
        exp_wr = exp_wr + NN;
        in_wr  = in_wr + NN;
    endtask

    task automatic wait_done();
        int t = 0;
        while (nout < exp_wr && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (N + 4) @(negedge clk);
        #5;
    endtask

    function automatic mat_t table_mat(int idx);
        mat_t m;
        for (int k = 0; k < NN; k++) m[k] = VEC[idx*NN + k];
        return m;
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        int base_in, base_out;
        mat_t cur, clo;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // table walk, no stalls: R2 R3 R4 values, R5 latency, R7 drain gap
        base_in  = nin;
        base_out = nout;
        for (int t = 0; t < 3; t++) begin
            push(table_mat(t), step_model(table_mat(t)), "R2/R3/R4");
        end
        wait_done();
        chk(nout - base_out == 3*NN, "R6 output count", nout - base_out, 3*NN);
        chk(out_cyc[base_out] - in_cyc[base_in] == N + 2, "R5 first output latency",
            out_cyc[base_out] - in_cyc[base_in], N + 2);
        chk(in_cyc[base_in + NN] - in_cyc[base_in + NN - 1] == N + 2, "R7 drain gap",
            in_cyc[base_in + NN] - in_cyc[base_in + NN - 1], N + 2);
        chk(in_cyc[base_in + 2*NN] - in_cyc[base_in + 2*NN - 1] == N + 2, "R7 drain gap 2",
            in_cyc[base_in + 2*NN] - in_cyc[base_in + 2*NN - 1], N + 2);

        // same table under random backpressure and input bubbles: R6 R7
        bp_mode  = 1'b1;
        gap_mode = 1'b1;
        base_out = nout;
        for (int t = 0; t < 3; t++) begin
            push(table_mat(t), step_model(table_mat(t)), "R6/R7");
        end
        wait_done();
        chk(nout - base_out == 3*NN, "R6 output count under stalls", nout - base_out, 3*NN);

        // repeated passes: closure after N passes, rotation after one more (R8)
        cur = table_mat(0);
        clo = fw_model(cur);
        base_out = nout;
        for (int p = 0; p <= N; p++) begin
            mat_t nxt;
            nxt = step_model(cur);
            if (p < N - 1)       push(cur, nxt, "R8 pass");
            else if (p == N - 1) push(cur, clo, "R8 closure");
            else                 push(cur, rot_model(clo), "R8 extra pass");
            cur = nxt;
        end
        wait_done();
        chk(nout - base_out == (N + 1)*NN, "R8 output count", nout - base_out, (N + 1)*NN);

        bp_mode  = 1'b0;
        gap_mode = 1'b0;
        @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R6 idle after all outputs", int'(out_valid), 0);

        $display("CHECKS %0d ERRORS %0d", main_chk + mon_chk, main_err + mon_err);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", main_chk + mon_chk + 1, main_err + mon_err + 1);
        $finish;
    end

endmodule